// File: doc/BRIEF.md
# Vector Byte-Window Shift Unit

This block is one execute slice of a vector pipeline. Each cycle it takes a 32-bit instruction word and two 128-bit operands that the register file has already read. When the word is a byte-window shift, it returns a 16-byte result and the decoded register indices one clock later. Bit numbering in the instruction word runs from bit 0 at the MSB (raw bit 31) to bit 31 at the LSB (raw bit 0). In the requirements below, raw bit positions are written as `raw[n]`.

Two encodings are decoded. The narrow form addresses 32 vector registers with contiguous 5-bit fields. The wide form addresses 128 registers, and each 7-bit index is assembled from fields that are not next to each other. The 4-bit shift amount sits in `raw[9:6]` in both forms.

The result is a 16-byte window cut from the 32-byte value formed by placing source A above source B. Bytes are counted from the most significant end, and the window starts at byte `sh`. Register file access, hazards and write-back belong to the surrounding pipeline.

Top module: `vbw_shift_unit`

## Requirements
- R1: A word with `raw[31:26]` = 4 and `raw[5:0]` = 44 is recognised as the narrow form, and `hit_o` goes high.
- R2: A word with `raw[31:26]` = 4 and `raw[4]` = 1 is recognised as the wide form, and `hit_o` goes high.
- R3: Any other word drives `hit_o` low, and `result_o`, `rd_o`, `ra_o` and `rb_o` all to zero.
- R4: In the narrow form, `rd_o` = `raw[25:21]`, `ra_o` = `raw[20:16]` and `rb_o` = `raw[15:11]`, each zero-extended to 7 bits. `raw[10]` has no effect on the shift amount.
- R5: In the wide form, `rd_o` = {`raw[3:2]`, `raw[25:21]`}, `ra_o` = {`raw[10]`, `raw[5]`, `raw[20:16]`} and `rb_o` = {`raw[1:0]`, `raw[15:11]`}.
- R6: For a recognised word with `sh` = `raw[9:6]`, result byte i (byte 0 = bits 127:120) equals byte i+sh of {A, B}, where byte 0 of that 256-bit value is `src_a_i[127:120]`. This is the same as (A << 8·sh) | (B >> 8·(16−sh)).
- R7: A shift of 0 returns `src_a_i` unchanged.
- R8: A shift of 15 returns the lowest byte of A followed by the upper 15 bytes of B.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. A change of input does not alter the outputs before the next edge.
- R10: While `rst_n` is low, all outputs are zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 128 | Upper operand of the concatenation |
| src_b_i | input | 128 | Lower operand of the concatenation |
| hit_o | output | 1 | Word recognised as a byte-window shift |
| rd_o | output | 7 | Destination register index |
| ra_o | output | 7 | Source A register index |
| rb_o | output | 7 | Source B register index |
| result_o | output | 128 | Selected 16-byte window |

## Verification
The only state is the single output register, so any fault shows up at the ports exactly one edge after the word that exposes it. A wrong candidate in the byte multiplexer shows as a result that is off by whole bytes, but only for the shift values that reach that candidate. For this reason, all sixteen shift values are swept in both forms. A swapped high bit in the wide-form index shows only when that bit is set, so random 7-bit indices are used together with an all-ones word. A decode that is too loose shows as `hit_o` set, with a non-zero result, on the words that should be rejected.

// File: rtl/vbw_pkg.sv
package vbw_pkg;
    localparam int INSN_W   = 32;
    localparam int IDX_W    = 7;
    localparam int NIDX_W   = 5;
    localparam int SH_W     = 4;
    localparam int OPC_W    = 6;

    localparam logic [OPC_W-1:0] OPC_VEC    = 6'd4;
    localparam logic [OPC_W-1:0] XO_NARROW  = 6'd44;

    typedef enum logic [1:0] {
        FORM_NONE   = 2'd0,
        FORM_NARROW = 2'd1,
        FORM_WIDE   = 2'd2
    } form_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] rb;
        logic [SH_W-1:0]  sh;
    } dec_t;
endpackage

// File: rtl/vbw_decode.sv
module vbw_decode
    import vbw_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output dec_t              dec_o
);
    logic [OPC_W-1:0] opc;
    logic [OPC_W-1:0] xo;
    form_e            form;

    assign opc = insn_i[31:26];
    assign xo  = insn_i[5:0];

    // Wide form: opcode 4 with raw[4] set. Narrow form: opcode 4 with XO 44.
    // The value 44 has raw[4] clear, so the two never overlap.
    always_comb begin
        if (opc == OPC_VEC && insn_i[4])
            form = FORM_WIDE;
        else if (opc == OPC_VEC && xo == XO_NARROW)
            form = FORM_NARROW;
        else
            form = FORM_NONE;
    end

    always_comb begin
        dec_o = '0;
        unique case (form)
            FORM_NARROW: begin
                dec_o.hit = 1'b1;
                dec_o.rd  = {{(IDX_W-NIDX_W){1'b0}}, insn_i[25:21]};
                dec_o.ra  = {{(IDX_W-NIDX_W){1'b0}}, insn_i[20:16]};
                dec_o.rb  = {{(IDX_W-NIDX_W){1'b0}}, insn_i[15:11]};
                dec_o.sh  = insn_i[9:6];
            end
            FORM_WIDE: begin
                dec_o.hit = 1'b1;
                dec_o.rd  = {insn_i[3:2], insn_i[25:21]};
                dec_o.ra  = {insn_i[10], insn_i[5], insn_i[20:16]};
                dec_o.rb  = {insn_i[1:0], insn_i[15:11]};
                dec_o.sh  = insn_i[9:6];
            end
            FORM_NONE: begin
                dec_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/vbw_window_mux.sv
module vbw_window_mux #(
    parameter int BYTES  = 16,
    parameter int LANE_W = 8
) (
    input  logic [BYTES*LANE_W-1:0]  a_i,
    input  logic [BYTES*LANE_W-1:0]  b_i,
    input  logic [$clog2(BYTES)-1:0] sh_i,
    output logic [BYTES*LANE_W-1:0]  y_o
);
    localparam int VEC_W = BYTES * LANE_W;
    localparam int CAT_W = 2 * VEC_W;

    logic [CAT_W-1:0] cat;
    logic [VEC_W-1:0] cand [BYTES];

    assign cat = {a_i, b_i};

    // Candidate s is the window that starts s lanes below the top of {a, b}.
    for (genvar s = 0; s < BYTES; s++) begin : g_cand
        assign cand[s] = cat[CAT_W-1-s*LANE_W -: VEC_W];
    end

    always_comb y_o = cand[sh_i];
endmodule

// File: rtl/vbw_out_stage.sv
module vbw_out_stage
    import vbw_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dec_t             dec_i,
    input  logic [VEC_W-1:0] win_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] rd_o,
    output logic [IDX_W-1:0] ra_o,
    output logic [IDX_W-1:0] rb_o,
    output logic [VEC_W-1:0] result_o
);
    logic [VEC_W-1:0] result_d;

    always_comb result_d = dec_i.hit ? win_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_o    <= 1'b0;
            rd_o     <= '0;
            ra_o     <= '0;
            rb_o     <= '0;
            result_o <= '0;
        end else begin
            hit_o    <= dec_i.hit;
            rd_o     <= dec_i.rd;
            ra_o     <= dec_i.ra;
            rb_o     <= dec_i.rb;
            result_o <= result_d;
        end
    end
endmodule

// File: rtl/vbw_shift_unit.sv
module vbw_shift_unit
    import vbw_pkg::*;
#(
    parameter int BYTES  = 16,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INSN_W-1:0]       insn_i,
    input  logic [BYTES*LANE_W-1:0] src_a_i,
    input  logic [BYTES*LANE_W-1:0] src_b_i,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        rd_o,
    output logic [IDX_W-1:0]        ra_o,
    output logic [IDX_W-1:0]        rb_o,
    output logic [BYTES*LANE_W-1:0] result_o
);
    localparam int VEC_W = BYTES * LANE_W;

    dec_t             dec;
    logic [VEC_W-1:0] win;

    vbw_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    vbw_window_mux #(
        .BYTES  (BYTES),
        .LANE_W (LANE_W)
    ) u_mux (
        .a_i  (src_a_i),
        .b_i  (src_b_i),
        .sh_i (dec.sh),
        .y_o  (win)
    );

    vbw_out_stage #(
        .VEC_W (VEC_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_i    (dec),
        .win_i    (win),
        .hit_o    (hit_o),
        .rd_o     (rd_o),
        .ra_o     (ra_o),
        .rb_o     (rb_o),
        .result_o (result_o)
    );
endmodule

// File: rtl/vbw_shift_unit_chk.sv
module vbw_shift_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [31:0]  insn_i,
    input logic [127:0] src_a_i,
    input logic [127:0] src_b_i,
    input logic         hit_o,
    input logic [6:0]   rd_o,
    input logic [6:0]   ra_o,
    input logic [6:0]   rb_o,
    input logic [127:0] result_o
);
    logic         is_op;
    logic         is_wide;
    logic         is_narrow;
    logic [127:0] exp_win;

    assign is_op     = (insn_i[31:26] == 6'd4);
    assign is_wide   = is_op && insn_i[4];
    assign is_narrow = is_op && !insn_i[4] && (insn_i[5:0] == 6'd44);
    assign exp_win   = (src_a_i << {insn_i[9:6], 3'b000})
                     | (src_b_i >> (9'd128 - {2'b00, insn_i[9:6], 3'b000}));

    AST_NARROW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        is_narrow |=> hit_o); // R1
    AST_WIDE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        is_wide |=> hit_o); // R2
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (result_o == '0 && rd_o == '0 && ra_o == '0 && rb_o == '0)); // R3
    AST_NARROW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        is_narrow |=> (rd_o == {2'b00, $past(insn_i[25:21])} && rb_o == {2'b00, $past(insn_i[15:11])})); // R4
    AST_WIDE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        is_wide |=> (ra_o == {$past(insn_i[10]), $past(insn_i[5]), $past(insn_i[20:16])})); // R5
    AST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_narrow || is_wide) |=> (result_o == $past(exp_win))); // R6
    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_narrow || is_wide) && insn_i[9:6] == 4'd0) |=> (result_o == $past(src_a_i))); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!hit_o && result_o == '0)); // R10
endmodule

bind vbw_shift_unit vbw_shift_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .insn_i   (insn_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .hit_o    (hit_o),
    .rd_o     (rd_o),
    .ra_o     (ra_o),
    .rb_o     (rb_o),
    .result_o (result_o)
);

// File: tb/sim_vbw_shift_unit.sv
`timescale 1ns/1ps
module sim_vbw_shift_unit;
    localparam int CLK_NS = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  insn = 32'h1000002C;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         hit;
    logic [6:0]   rd, ra, rb;
    logic [127:0] result;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    vbw_shift_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .insn_i   (insn),
        .src_a_i  (src_a),
        .src_b_i  (src_b),
        .hit_o    (hit),
        .rd_o     (rd),
        .ra_o     (ra),
        .rb_o     (rb),
        .result_o (result)
    );

    // Each entry packs {insn[31:0], hit, rd[6:0], ra[6:0], rb[6:0]}.
    localparam int NTAB = 8;
    localparam logic [53:0] DTAB [NTAB] = '{
        {32'h1000002C, 1'b1, 7'd0,   7'd0,   7'd0  },
        {32'h10000010, 1'b1, 7'd0,   7'd0,   7'd0  },
        {32'h10A43EEC, 1'b1, 7'd5,   7'd4,   7'd7  },
        {32'h13FFFFFF, 1'b1, 7'd127, 7'd127, 7'd127},
        {32'h00000000, 1'b0, 7'd0,   7'd0,   7'd0  },
        {32'h1000002D, 1'b0, 7'd0,   7'd0,   7'd0  },
        {32'h1400002C, 1'b0, 7'd0,   7'd0,   7'd0  },
        {32'hFFFFFFFF, 1'b0, 7'd0,   7'd0,   7'd0  }
    };

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Byte k of {a, b}, counted from the most significant end.
    function automatic logic [127:0] ref_win(input logic [127:0] a, input logic [127:0] b,
                                             input logic [3:0] sh);
        logic [255:0] cat;
        logic [127:0] r;
        cat = {a, b};
        r = '0;
        for (int i = 0; i < 16; i++)
            r[127-8*i -: 8] = cat[255-8*(i+int'(sh)) -: 8];
        return r;
    endfunction

    function automatic logic [31:0] enc_narrow(input logic [4:0] d, input logic [4:0] a,
                                               input logic [4:0] b, input logic [3:0] sh);
        return {6'd4, d, a, b, 1'b0, sh, 6'd44};
    endfunction

    function automatic logic [31:0] enc_wide(input logic [6:0] d, input logic [6:0] a,
                                             input logic [6:0] b, input logic [3:0] sh);
        return {6'd4, d[4:0], a[4:0], b[4:0], a[6], sh, a[5], 1'b1, d[6:5], b[6:5]};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [6:0]   xd, xa, xb;
        logic [127:0] pa, pb;

        // R10: valid word applied during reset still gives zero outputs
        src_a = rnd128();
        src_b = rnd128();
        repeat (2) @(negedge clk);
        chk("R10 reset hit", {127'd0, hit}, 128'd0);
        chk("R10 reset result", result, 128'd0);
        rst_n = 1'b1;

        // Decode table: R1 R2 R3 R4 R5
        for (int i = 0; i < NTAB; i++) begin
            insn  = DTAB[i][53:22];
            src_a = rnd128();
            src_b = rnd128();
            pa = src_a;
            pb = src_b;
            @(negedge clk);
            chk("R1/R2/R3 table hit", {127'd0, hit}, {127'd0, DTAB[i][21]});
            chk("R4/R5 table rd", {121'd0, rd}, {121'd0, DTAB[i][20:14]});
            chk("R4/R5 table ra", {121'd0, ra}, {121'd0, DTAB[i][13:7]});
            chk("R4/R5 table rb", {121'd0, rb}, {121'd0, DTAB[i][6:0]});
            chk("R3/R6 table result", result,
                DTAB[i][21] ? ref_win(pa, pb, DTAB[i][31:28]) : 128'd0);
        end

        // Shift sweep, both forms: R6 R7 R8
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 16; s++) begin
                xd = 7'($urandom);
                xa = 7'($urandom);
                xb = 7'($urandom);
                if (f == 0) begin
                    xd[6:5] = 2'b00;
                    xa[6:5] = 2'b00;
                    xb[6:5] = 2'b00;
                    insn = enc_narrow(xd[4:0], xa[4:0], xb[4:0], 4'(s));
                end else begin
                    insn = enc_wide(xd, xa, xb, 4'(s));
                end
                src_a = rnd128();
                src_b = rnd128();
                pa = src_a;
                pb = src_b;
                @(negedge clk);
                chk(f == 0 ? "R1 sweep hit" : "R2 sweep hit", {127'd0, hit}, 128'd1);
                chk(f == 0 ? "R4 sweep rd" : "R5 sweep rd", {121'd0, rd}, {121'd0, xd});
                chk(f == 0 ? "R4 sweep ra" : "R5 sweep ra", {121'd0, ra}, {121'd0, xa});
                chk(f == 0 ? "R4 sweep rb" : "R5 sweep rb", {121'd0, rb}, {121'd0, xb});
                chk("R6 sweep result", result, ref_win(pa, pb, 4'(s)));
                if (s == 0)  chk("R7 shift zero", result, pa);
                if (s == 15) chk("R8 shift max", result, {pa[7:0], pb[127:8]});
            end
        end

        // R8 with a known byte ramp
        src_a = 128'h000102030405060708090A0B0C0D0E0F;
        src_b = 128'h101112131415161718191A1B1C1D1E1F;
        insn  = enc_narrow(5'd1, 5'd2, 5'd3, 4'd15);
        @(negedge clk);
        chk("R8 ramp", result, 128'h0F101112131415161718191A1B1C1D1E);

        // R4: raw[10] set in the narrow form leaves the shift at raw[9:6]
        insn = enc_narrow(5'd9, 5'd10, 5'd11, 4'd3) | 32'h0000_0400;
        @(negedge clk);
        chk("R4 raw10 ignored", result, ref_win(src_a, src_b, 4'd3));

        // R9: input change does not reach outputs before the edge
        insn = 32'hFFFFFFFF;
        #1;
        chk("R9 held before edge", result, ref_win(src_a, src_b, 4'd3));
        @(negedge clk);
        chk("R9/R3 miss after edge", result, 128'd0);

        // R10: asynchronous reset mid-run
        insn = enc_wide(7'd100, 7'd64, 7'd33, 4'd5);
        @(negedge clk);
        chk("R2 pre-reset hit", {127'd0, hit}, 128'd1);
        rst_n = 1'b0;
        #1;
        chk("R10 async hit", {127'd0, hit}, 128'd0);
        chk("R10 async result", result, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 release rd", {121'd0, rd}, 128'd100);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule